// File: doc/BRIEF.md
# Three-Register Exchange Sequencer

This block exchanges the contents of two data registers, A and B, over a single shared bus. A third register, T, holds one value while the exchange is in progress. A one-hot controller with four states steps through three bus transfers. In each transfer it selects exactly one register to drive the bus and exactly one register to capture from it. The controller marks the last transfer with a one-cycle completion flag.

Before an exchange, the surrounding logic preloads A and B through a parallel load port. It then raises `start`. The bus, the drive and capture enables, and all three register values are visible at the ports, so the datapath can be watched at every step. If `start` is still high when an exchange ends, the next exchange begins right away. Two exchanges in a row therefore put the original contents back.

Top module: `swap_ctrl_top`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the controller returns to idle and A, B and T are cleared to zero. While in idle, `done`, `drv_en`, `cap_en` and `bus_q` are all zero.
- R2: The state register has four flip-flops, one per state, and exactly one of them is set at any time after reset.
- R3: The controller stays idle while `start` is low. When `start` is high at an edge, the controller leaves idle. It then passes through the three transfer states, one per cycle, whatever `start` does, and returns to idle.
- R4: In the first transfer state, `drv_en` = 3'b010 (B drives) and `cap_en` = 3'b100 (T captures). At the next edge, T takes the old value of B.
- R5: In the second transfer state, `drv_en` = 3'b001 (A drives) and `cap_en` = 3'b010 (B captures). At the next edge, B takes the old value of A.
- R6: In the third transfer state, `drv_en` = 3'b100 (T drives), `cap_en` = 3'b001 (A captures) and `done` = 1. At the next edge, A takes the value of T.
- R7: `done` is high for exactly one cycle per exchange, in the third transfer state. After that edge, A and B hold each other's earlier values and T holds the earlier B.
- R8: `bus_q` equals the register selected by `drv_en`: bit 0 selects A, bit 1 selects B, bit 2 selects T. It is zero when no bit of `drv_en` is set.
- R9: With `load_en` high in idle, `load_a` and `load_b` are written into A and B at the edge. In any other state, `load_en` has no effect, and T is never written by the load port.
- R10: If `start` is high in the third transfer state, the controller spends one cycle in idle and then starts a new exchange. Two back-to-back exchanges restore A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Requests an exchange; sampled in idle |
| load_en | input | 1 | Preload strobe, honoured only in idle |
| load_a | input | DW | Preload value for register A |
| load_b | input | DW | Preload value for register B |
| reg_a | output | DW | Current contents of A |
| reg_b | output | DW | Current contents of B |
| reg_t | output | DW | Current contents of T |
| drv_en | output | 3 | Bus drive enables {T, B, A} |
| cap_en | output | 3 | Bus capture enables {T, B, A} |
| bus_q | output | DW | Shared bus value |
| done | output | 1 | High during the final transfer |

## Verification
The bench preloads patterns where the two values are unequal, are complementary, or are the same. It then checks the enables and the bus value in every transfer state. If a design swapped the order of two transfers, T would be overwritten before it was read, and A and B would end up equal instead of exchanged.

Two further cases are aimed at the port rules. A preload pulse is applied in the last transfer state. A design that did not gate the load port on idle would let the pulse corrupt B. Separately, `start` is held high across two exchanges. A design that looped from the last transfer state straight back into the first, or that raised `done` twice, would break the one-cycle idle gap and the restored values.

A reset in the middle of an exchange checks that the registers and the controller go back to their cleared idle state.

// File: rtl/swap_pkg.sv
// Shared constants for the register exchange sequencer.
// Assumes exactly three registers on the bus and a four-state one-hot controller.
package swap_pkg;
    localparam int NSTATE = 4;
    localparam int NREG   = 3;

    // Bit positions in the one-hot state vector.
    localparam int ST_IDLE = 0;
    localparam int ST_B2T  = 1;
    localparam int ST_A2B  = 2;
    localparam int ST_T2A  = 3;

    // Bit positions in the drive and capture enable vectors.
    localparam int RG_A = 0;
    localparam int RG_B = 1;
    localparam int RG_T = 2;
endpackage

// File: rtl/swap_fsm.sv
// One-hot controller for the exchange.
// Each state has its own flip-flop, and the next-state equations are written
// directly from the state sequence. The controller also decodes the drive and
// capture enables and the done flag from the state vector.
// Assumes synchronous active-low reset.
module swap_fsm
    import swap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [NSTATE-1:0] st,
    output logic [NREG-1:0]   drv_en,
    output logic [NREG-1:0]   cap_en,
    output logic              done
);
    logic [NSTATE-1:0] st_nx;

    // Next-state equations, one per state flip-flop.
    always_comb begin
        st_nx[ST_IDLE] = st[ST_T2A] | (~start & st[ST_IDLE]);
        st_nx[ST_B2T]  = start & st[ST_IDLE];
        st_nx[ST_A2B]  = st[ST_B2T];
        st_nx[ST_T2A]  = st[ST_A2B];
    end

    // State flip-flops; reset leaves only the idle bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= NSTATE'(1) << ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Per-state enables: each transfer state picks one source and one sink.
    always_comb begin
        drv_en       = '0;
        cap_en       = '0;
        drv_en[RG_B] = st[ST_B2T];
        cap_en[RG_T] = st[ST_B2T];
        drv_en[RG_A] = st[ST_A2B];
        cap_en[RG_B] = st[ST_A2B];
        drv_en[RG_T] = st[ST_T2A];
        cap_en[RG_A] = st[ST_T2A];
        done         = st[ST_T2A];
    end
endmodule

// File: rtl/swap_bus.sv
// Shared bus multiplexer.
// The bus is an AND-OR of each register with its drive enable.
// Assumes the controller sets at most one drive enable at a time.
// With no enable set, the bus is zero.
module swap_bus
    import swap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [NREG-1:0]         drv_en,
    input  logic [NREG-1:0][DW-1:0] regs,
    output logic [DW-1:0]           bus_q
);
    logic [NREG:0][DW-1:0] acc;

    assign acc[0] = '0;

    // Chain one OR stage per register source.
    for (genvar i = 0; i < NREG; i++) begin : g_src
        assign acc[i+1] = acc[i] | (regs[i] & {DW{drv_en[i]}});
    end

    assign bus_q = acc[NREG];
endmodule

// File: rtl/swap_regfile.sv
// The three bus registers A, B and T.
// A register captures the bus when its capture enable is set. Otherwise it
// takes its preload value when its write strobe is set.
// Assumes capture and preload never coincide; the top allows preload only in idle.
module swap_regfile
    import swap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0]         cap_en,
    input  logic [DW-1:0]           bus_q,
    input  logic [NREG-1:0]         ld_we,
    input  logic [NREG-1:0][DW-1:0] ld_val,
    output logic [NREG-1:0][DW-1:0] regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold, capture from the bus, or take the preload value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (cap_en[i]) begin
                regs[i] <= bus_q;
            end else if (ld_we[i]) begin
                regs[i] <= ld_val[i];
            end
        end
    end
endmodule

// File: rtl/swap_ctrl_top.sv
// Top level of the register exchange sequencer.
// Connects the one-hot controller, the register bank and the bus multiplexer.
// The preload port is gated on the idle state, and T can never be preloaded.
module swap_ctrl_top
    import swap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load_en,
    input  logic [DW-1:0] load_a,
    input  logic [DW-1:0] load_b,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic [DW-1:0] reg_t,
    output logic [2:0]    drv_en,
    output logic [2:0]    cap_en,
    output logic [DW-1:0] bus_q,
    output logic          done
);
    logic [NSTATE-1:0]       st;
    logic [NREG-1:0]         ld_we;
    logic [NREG-1:0][DW-1:0] ld_val;
    logic [NREG-1:0][DW-1:0] regs;

    swap_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .st     (st),
        .drv_en (drv_en),
        .cap_en (cap_en),
        .done   (done)
    );

    // Preload strobes: A and B only, and only in idle.
    always_comb begin
        ld_we         = '0;
        ld_we[RG_A]   = load_en & st[ST_IDLE];
        ld_we[RG_B]   = load_en & st[ST_IDLE];
        ld_val        = '0;
        ld_val[RG_A]  = load_a;
        ld_val[RG_B]  = load_b;
    end

    swap_regfile #(.DW(DW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .bus_q  (bus_q),
        .ld_we  (ld_we),
        .ld_val (ld_val),
        .regs   (regs)
    );

    swap_bus #(.DW(DW)) u_bus (
        .drv_en (drv_en),
        .regs   (regs),
        .bus_q  (bus_q)
    );

    // Register contents brought out for observation.
    assign reg_a = regs[RG_A];
    assign reg_b = regs[RG_B];
    assign reg_t = regs[RG_T];
endmodule

// File: rtl/swap_ctrl_chk.sv
// Property checker for swap_ctrl_top, attached with the bind below.
module swap_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          load_en,
    input logic [3:0]    st,
    input logic [2:0]    drv_en,
    input logic [2:0]    cap_en,
    input logic [DW-1:0] bus_q,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] reg_b,
    input logic [DW-1:0] reg_t,
    input logic          done
);
    // R2
    one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st) == 1);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] && !start) |=> st[0]);

    // R3
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st[1] |=> (st[2] && !st[1]));

    // R4
    t_gets_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en[2] |=> reg_t == $past(reg_b));

    // R5
    b_gets_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en[1] |=> reg_b == $past(reg_a));

    // R6
    a_gets_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en[0] |=> reg_a == $past(reg_t));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    bus_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en) && (drv_en[2] ? bus_q == reg_t :
                             drv_en[1] ? bus_q == reg_b :
                             drv_en[0] ? bus_q == reg_a : bus_q == '0));

    // R9
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !st[0] && !cap_en[0]) |=> reg_a == $past(reg_a));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (st[0] ##1 st[1]));
endmodule

bind swap_ctrl_top swap_ctrl_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load_en (load_en),
    .st      (st),
    .drv_en  (drv_en),
    .cap_en  (cap_en),
    .bus_q   (bus_q),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .reg_t   (reg_t),
    .done    (done)
);

// File: tb/swap_ctrl_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected {A,B,T} after each exchange,
// and the monitor pops and compares it on the cycle after done.
module swap_ctrl_top_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          load_en = 1'b0;
    logic [DW-1:0] load_a = '0;
    logic [DW-1:0] load_b = '0;
    logic [DW-1:0] reg_a, reg_b, reg_t, bus_q;
    logic [2:0]    drv_en, cap_en;
    logic          done;

    int total = 0;
    int bad   = 0;
    logic [3*DW-1:0] sb_q[$];
    bit seen_done = 1'b0;
    bit finished  = 1'b0;

    always #10 clk = ~clk;

    swap_ctrl_top #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
        .load_a(load_a), .load_b(load_b), .reg_a(reg_a), .reg_b(reg_b),
        .reg_t(reg_t), .drv_en(drv_en), .cap_en(cap_en), .bus_q(bus_q),
        .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Monitor: after a cycle with done high, compare the registers with the scoreboard (R7).
    always @(negedge clk) begin
        if (rst_n && seen_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", {8'h0, reg_a, reg_b, reg_t}, 32'h0);
            end else begin
                logic [3*DW-1:0] e;
                e = sb_q.pop_front();
                chk({reg_a, reg_b, reg_t} == e, "R7 exchange result",
                    {8'h0, reg_a, reg_b, reg_t}, {8'h0, e});
            end
        end
        seen_done = done && rst_n;
    end

    task automatic swap_once(input logic [DW-1:0] a0, input logic [DW-1:0] b0);
        load_en = 1'b1; load_a = a0; load_b = b0;
        @(negedge clk); load_en = 1'b0;
        chk(reg_a == a0 && reg_b == b0, "R9 preload", {reg_a, reg_b}, {a0, b0});
        chk(drv_en == 0 && cap_en == 0 && done == 0, "R3 idle", {drv_en, cap_en, done}, 0);
        sb_q.push_back({b0, a0, b0});
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(drv_en == 3'b010 && cap_en == 3'b100, "R4 enables", {drv_en, cap_en}, 6'b010100);
        chk(bus_q == b0, "R8 bus B", bus_q, b0);
        @(negedge clk);
        chk(drv_en == 3'b001 && cap_en == 3'b010, "R5 enables", {drv_en, cap_en}, 6'b001010);
        chk(reg_t == b0, "R4 T captured", reg_t, b0);
        chk(bus_q == a0, "R8 bus A", bus_q, a0);
        @(negedge clk);
        chk(drv_en == 3'b100 && cap_en == 3'b001 && done, "R6 enables",
            {drv_en, cap_en, done}, 7'b1000011);
        chk(reg_b == a0, "R5 B captured", reg_b, a0);
        chk(bus_q == b0, "R8 bus T", bus_q, b0);
        load_en = 1'b1; load_a = ~a0; load_b = ~b0;   // must be ignored (R9)
        @(negedge clk); load_en = 1'b0;
        chk(!done && drv_en == 0, "R7 done single", {done, drv_en}, 0);
        chk(reg_b == a0, "R9 load ignored", reg_b, a0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(reg_a == 0 && reg_b == 0 && reg_t == 0, "R1 regs", {reg_a, reg_b, reg_t}, 0);
        chk(drv_en == 0 && cap_en == 0 && done == 0 && bus_q == 0, "R1 outputs",
            {drv_en, cap_en, done, bus_q}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(drv_en == 0 && !done, "R3 hold idle", {drv_en, done}, 0);
            chk(bus_q == 0, "R8 bus idle zero", bus_q, 0);
        end

        swap_once(8'h3C, 8'hA5);
        swap_once(8'h00, 8'hFF);
        swap_once(8'h7E, 8'h7E);

        // Back-to-back exchanges with start held high (R10).
        load_en = 1'b1; load_a = 8'h11; load_b = 8'h22;
        @(negedge clk); load_en = 1'b0;
        sb_q.push_back({8'h22, 8'h11, 8'h22});
        sb_q.push_back({8'h11, 8'h22, 8'h11});
        start = 1'b1;
        begin
            int ndone = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (done) ndone++;
                if (i == 3) chk(drv_en == 0 && !done, "R10 idle gap", {drv_en, done}, 0);
                if (i == 4) begin
                    chk(drv_en == 3'b010, "R10 restart", drv_en, 3'b010);
                    start = 1'b0;
                end
            end
            chk(ndone == 2, "R7 done count", ndone, 2);
            chk(reg_a == 8'h11 && reg_b == 8'h22, "R10 restored", {reg_a, reg_b}, 16'h1122);
        end

        // Reset in the middle of an exchange (R1, R2).
        load_en = 1'b1; load_a = 8'h5A; load_b = 8'hC3;
        @(negedge clk); load_en = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(reg_t == 8'hC3, "R4 T mid", reg_t, 8'hC3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(reg_a == 0 && reg_b == 0 && reg_t == 0, "R1 mid reset regs",
            {reg_a, reg_b, reg_t}, 0);
        chk(drv_en == 0 && !done, "R1 mid reset idle", {drv_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv_en == 0 && cap_en == 0, "R2 idle after reset", {drv_en, cap_en}, 0);
        chk(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule